// File: doc/BRIEF.md
# Linked-List Memory Copy Engine

This block is a single-channel memory-to-memory mover that sits on a shared memory bus beside a CPU. Each element it moves is one word: it reads the word at the current source address, then writes that word to the current destination address, and both addresses then advance by one. Software programs a source, a destination and a word count and then sets a go bit. Alternatively, it points the engine at a list of descriptors in memory, which the engine fetches and follows by itself.

The engine asks for the bus with a request/grant handshake. It only drives the active-low memory strobes while it is granted. A policy field sets how long it keeps the bus: one element per tenure, a programmable group of elements, or the whole job. A peripheral request line can pace the work, so that each element waits for that line. When the whole job has finished, an interrupt line rises and stays high until software writes a clear command.

Top module: `dmac_chain_top`

## Requirements
- R1: Each element reads the source word (rd strobe) and writes it two cycles later to the destination (we strobe). After a job of N words, destination words 0..N-1 equal source words 0..N-1, and the word at destination+N is left unchanged.
- R2: Register writes use `cfg_sel`: 0 source, 1 destination, 2 word count, 3 descriptor pointer, 4 group length, 5 control, 6 interrupt clear. A control write with bit 0 set starts a job. In the control word, bit 1 selects request pacing, bit 2 selects list mode, and bits 4:3 select the bus policy (0 single, 1 group, 2 or 3 whole job).
- R3: With pacing selected, no element read begins unless `dreq` was high in the previous cycle. While `dreq` stays low, no write strobe occurs.
- R4: In list mode, the descriptor at pointer P is four words: P+0 word count, P+1 source, P+2 destination, P+3 next pointer. A next pointer of zero ends the list.
- R5: Under the single policy, `bus_req` drops after every element, so a job of N words takes N bus tenures.
- R6: Under the group policy, a job of N words takes ceil(N/L) tenures. L is the group length register, its reset value is 4, and a written value of 0 acts as 1.
- R7: Under the whole-job policy, an entire job, including every descriptor fetch of a list, takes one tenure.
- R8: The strobes `mem_cs_n`, `mem_rd_n` and `mem_we_n` are active low. They are asserted only while both `bus_req` and `bus_gnt` are high. After reset they are high, and `bus_req`, `busy` and `irq` are low.
- R9: `irq` rises only when the last word of the last descriptor has been written, and it stays high until a write with `cfg_sel` = 6.
- R10: A word count of zero finishes with no memory bus cycle for that job or descriptor. A standalone job of zero words raises `irq` at once.
- R11: A start written while a job is in progress is ignored, and the running job keeps its original addresses, count and policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| dreq | input | 1 | Peripheral pacing request |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | AW | Memory write data |
| mem_rdata | input | AW | Memory read data, valid the cycle after a read strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Job in progress |

## Verification
The bench builds the block with its defaults: a 16-bit word and address width, an 8-bit group length register, and a group length of 4 at reset. A 512-word memory model holds the sources, a sentinel-filled destination area and a three-entry descriptor list whose middle entry is empty. The group length is a register, so one build can cover lengths 0, 1, 2, 3 and 4 against job sizes that divide evenly and that do not. This exercises the tenure boundary both exactly at the end of a job and in the middle of one.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAITB,
        S_ACQ,
        S_DRD,
        S_DLAT,
        S_HOLD,
        S_RD,
        S_LAT,
        S_WR
    } dstate_e;

    typedef enum logic [1:0] {
        POL_SINGLE = 2'd0,
        POL_GROUP  = 2'd1,
        POL_WHOLE  = 2'd2,
        POL_WHOLE2 = 2'd3
    } policy_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_DESC = 3'd3;
    localparam logic [2:0] SEL_GLEN = 3'd4;
    localparam logic [2:0] SEL_CTRL = 3'd5;
    localparam logic [2:0] SEL_CLR  = 3'd6;

    localparam int CTRL_GO    = 0;
    localparam int CTRL_PACE  = 1;
    localparam int CTRL_LIST  = 2;
    localparam int CTRL_POL_L = 3;

endpackage

// File: rtl/dmac_cfg_regs.sv
module dmac_cfg_regs
    import dmac_pkg::*;
#(
    parameter int AW       = 16,
    parameter int GW       = 8,
    parameter int GLEN_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] cnt_o,
    output logic [AW-1:0] desc_o,
    output logic [GW-1:0] glen_o,
    output logic          pace_o,
    output logic          list_o,
    output logic [1:0]    pol_o,
    output logic          go_o,
    output logic          clr_o
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        logic [AW-1:0] desc;
        logic [GW-1:0] glen;
        logic          pace;
        logic          list;
        logic [1:0]    pol;
        logic          go;
        logic          clr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.go  = 1'b0;
        r_d.clr = 1'b0;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SRC:  r_d.src  = cfg_wdata;
                SEL_DST:  r_d.dst  = cfg_wdata;
                SEL_CNT:  r_d.cnt  = cfg_wdata;
                SEL_DESC: r_d.desc = cfg_wdata;
                SEL_GLEN: r_d.glen = cfg_wdata[GW-1:0];
                SEL_CTRL: begin
                    r_d.go   = cfg_wdata[CTRL_GO];
                    r_d.pace = cfg_wdata[CTRL_PACE];
                    r_d.list = cfg_wdata[CTRL_LIST];
                    r_d.pol  = cfg_wdata[CTRL_POL_L+1:CTRL_POL_L];
                end
                SEL_CLR:  r_d.clr  = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.glen <= GW'(GLEN_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign src_o  = r_q.src;
    assign dst_o  = r_q.dst;
    assign cnt_o  = r_q.cnt;
    assign desc_o = r_q.desc;
    assign glen_o = r_q.glen;
    assign pace_o = r_q.pace;
    assign list_o = r_q.list;
    assign pol_o  = r_q.pol;
    assign go_o   = r_q.go;
    assign clr_o  = r_q.clr;

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          clr,
    input  logic          pace,
    input  logic          list,
    input  logic [1:0]    pol,
    input  logic [GW-1:0] glen,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [AW-1:0] cfg_cnt,
    input  logic [AW-1:0] cfg_desc,
    input  logic          dreq,
    input  logic          bus_gnt,
    input  logic [AW-1:0] mem_rdata,
    output logic          bus_req,
    output logic          rd_en,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wdata,
    output logic          irq,
    output logic          busy,
    output logic          elem_rd,
    output logic          pace_act
);

    typedef struct packed {
        dstate_e       st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        logic [AW-1:0] nxt;
        logic [AW-1:0] ptr;
        logic [AW-1:0] data;
        logic [1:0]    widx;
        logic [GW-1:0] gcnt;
        logic          fetch;
        logic          pace;
        logic          list;
        policy_e       pol;
        logic          irq;
    } eng_t;

    eng_t r_d, r_q;

    logic [GW-1:0] glen_eff;
    logic [GW:0]   gnext;
    logic          group_full;
    logic          release_bus;
    dstate_e       elem_st;

    always_comb begin
        glen_eff    = (glen == '0) ? GW'(1) : glen;
        gnext       = {1'b0, r_q.gcnt} + (GW+1)'(1);
        group_full  = gnext >= {1'b0, glen_eff};
        release_bus = (r_q.pol == POL_SINGLE) ||
                      ((r_q.pol == POL_GROUP) && group_full);
        elem_st     = (r_q.pace && !dreq) ? S_HOLD : S_RD;

        r_d     = r_q;
        bus_req = 1'b0;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        addr    = '0;

        if (clr) r_d.irq = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (go) begin
                    r_d.pace = pace;
                    r_d.list = list;
                    r_d.pol  = policy_e'(pol);
                    r_d.widx = '0;
                    r_d.gcnt = '0;
                    if (list) begin
                        r_d.ptr   = cfg_desc;
                        r_d.fetch = 1'b1;
                        r_d.st    = S_WAITB;
                    end else begin
                        r_d.src   = cfg_src;
                        r_d.dst   = cfg_dst;
                        r_d.cnt   = cfg_cnt;
                        r_d.nxt   = '0;
                        r_d.fetch = 1'b0;
                        if (cfg_cnt == '0) r_d.irq = 1'b1;
                        else               r_d.st  = S_WAITB;
                    end
                end
            end
            S_WAITB: begin
                if (r_q.fetch || !r_q.pace || dreq) r_d.st = S_ACQ;
            end
            S_ACQ: begin
                bus_req  = 1'b1;
                r_d.gcnt = '0;
                if (bus_gnt) r_d.st = r_q.fetch ? S_DRD : elem_st;
            end
            S_DRD: begin
                bus_req = 1'b1;
                rd_en   = 1'b1;
                addr    = r_q.ptr + AW'(r_q.widx);
                r_d.st  = S_DLAT;
            end
            S_DLAT: begin
                bus_req = 1'b1;
                unique case (r_q.widx)
                    2'd0: r_d.cnt = mem_rdata;
                    2'd1: r_d.src = mem_rdata;
                    2'd2: r_d.dst = mem_rdata;
                    default: r_d.nxt = mem_rdata;
                endcase
                if (r_q.widx == 2'd3) begin
                    r_d.widx  = '0;
                    r_d.fetch = 1'b0;
                    if (r_q.cnt == '0) begin
                        if (mem_rdata != '0) begin
                            r_d.ptr   = mem_rdata;
                            r_d.fetch = 1'b1;
                            r_d.st    = S_DRD;
                        end else begin
                            r_d.irq = 1'b1;
                            r_d.st  = S_IDLE;
                        end
                    end else begin
                        r_d.st = elem_st;
                    end
                end else begin
                    r_d.widx = r_q.widx + 2'd1;
                    r_d.st   = S_DRD;
                end
            end
            S_HOLD: begin
                bus_req = 1'b1;
                if (dreq) r_d.st = S_RD;
            end
            S_RD: begin
                bus_req = 1'b1;
                rd_en   = 1'b1;
                addr    = r_q.src;
                r_d.st  = S_LAT;
            end
            S_LAT: begin
                bus_req  = 1'b1;
                r_d.data = mem_rdata;
                r_d.st   = S_WR;
            end
            S_WR: begin
                bus_req  = 1'b1;
                wr_en    = 1'b1;
                addr     = r_q.dst;
                r_d.src  = r_q.src + AW'(1);
                r_d.dst  = r_q.dst + AW'(1);
                r_d.cnt  = r_q.cnt - AW'(1);
                r_d.gcnt = gnext[GW-1:0];
                if (r_q.cnt == AW'(1)) begin
                    if (r_q.list && (r_q.nxt != '0)) begin
                        r_d.ptr   = r_q.nxt;
                        r_d.fetch = 1'b1;
                        r_d.widx  = '0;
                        r_d.st    = S_DRD;
                    end else begin
                        r_d.irq = 1'b1;
                        r_d.st  = S_IDLE;
                    end
                end else if (release_bus) begin
                    r_d.st = S_WAITB;
                end else begin
                    r_d.st = elem_st;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wdata    = r_q.data;
    assign irq      = r_q.irq;
    assign busy     = (r_q.st != S_IDLE);
    assign elem_rd  = (r_q.st == S_RD);
    assign pace_act = r_q.pace;

endmodule

// File: rtl/dmac_bus_gate.sv
module dmac_bus_gate #(
    parameter int AW = 16
) (
    input  logic          gnt,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] data_i,
    output logic          cs_n,
    output logic          rd_n,
    output logic          we_n,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] data_o
);

    always_comb begin
        rd_n   = !(rd_en && gnt);
        we_n   = !(wr_en && gnt);
        cs_n   = rd_n && we_n;
        addr_o = gnt ? addr_i : '0;
        data_o = (gnt && wr_en) ? data_i : '0;
    end

endmodule

// File: rtl/dmac_chain_top.sv
module dmac_chain_top
    import dmac_pkg::*;
#(
    parameter int AW       = 16,
    parameter int GW       = 8,
    parameter int GLEN_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dreq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_we_n,
    output logic          irq,
    output logic          busy
);

    logic [AW-1:0] src_w, dst_w, cnt_w, desc_w, addr_w, wdata_w;
    logic [GW-1:0] glen_w;
    logic [1:0]    pol_w;
    logic          pace_w, list_w, go_w, clr_w;
    logic          rd_w, wr_w, elem_rd_w, pace_act_w;

    dmac_cfg_regs #(.AW(AW), .GW(GW), .GLEN_RST(GLEN_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .src_o     (src_w),
        .dst_o     (dst_w),
        .cnt_o     (cnt_w),
        .desc_o    (desc_w),
        .glen_o    (glen_w),
        .pace_o    (pace_w),
        .list_o    (list_w),
        .pol_o     (pol_w),
        .go_o      (go_w),
        .clr_o     (clr_w)
    );

    dmac_engine #(.AW(AW), .GW(GW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_w),
        .clr       (clr_w),
        .pace      (pace_w),
        .list      (list_w),
        .pol       (pol_w),
        .glen      (glen_w),
        .cfg_src   (src_w),
        .cfg_dst   (dst_w),
        .cfg_cnt   (cnt_w),
        .cfg_desc  (desc_w),
        .dreq      (dreq),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .rd_en     (rd_w),
        .wr_en     (wr_w),
        .addr      (addr_w),
        .wdata     (wdata_w),
        .irq       (irq),
        .busy      (busy),
        .elem_rd   (elem_rd_w),
        .pace_act  (pace_act_w)
    );

    dmac_bus_gate #(.AW(AW)) u_gate (
        .gnt    (bus_gnt),
        .rd_en  (rd_w),
        .wr_en  (wr_w),
        .addr_i (addr_w),
        .data_i (wdata_w),
        .cs_n   (mem_cs_n),
        .rd_n   (mem_rd_n),
        .we_n   (mem_we_n),
        .addr_o (mem_addr),
        .data_o (mem_wdata)
    );

endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic mem_cs_n,
    input logic mem_rd_n,
    input logic mem_we_n,
    input logic irq,
    input logic busy,
    input logic dreq,
    input logic irq_clr,
    input logic elem_rd,
    input logic pace_act
);

    p_strobe_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (bus_gnt && bus_req));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && !bus_req));

    p_write_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $past(!mem_rd_n, 2));

    p_paced_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_rd && pace_act) |-> $past(dreq));

    p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    p_irq_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

endmodule

bind dmac_chain_top dmac_chain_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_cs_n (mem_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_we_n (mem_we_n),
    .irq      (irq),
    .busy     (busy),
    .dreq     (dreq),
    .irq_clr  (clr_w),
    .elem_rd  (elem_rd_w),
    .pace_act (pace_act_w)
);

// File: tb/dmac_chain_top_tb.sv
`timescale 1ns/1ps
module dmac_chain_top_tb;
    import dmac_pkg::*;

    localparam int AW = 16;
    localparam int GW = 8;
    localparam logic [15:0] SENT = 16'hDEAD;

    // {policy[1:0], group length[7:0], word count[7:0], expected tenures[7:0]}
    localparam logic [25:0] VEC [7] = '{
        {2'd0, 8'd4, 8'd5,  8'd5},
        {2'd1, 8'd4, 8'd10, 8'd3},
        {2'd1, 8'd3, 8'd9,  8'd3},
        {2'd2, 8'd4, 8'd7,  8'd1},
        {2'd1, 8'd1, 8'd3,  8'd3},
        {2'd2, 8'd2, 8'd1,  8'd1},
        {2'd1, 8'd0, 8'd2,  8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dreq = 1'b0;
    logic          bus_req, bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic          mem_cs_n, mem_rd_n, mem_we_n, irq, busy;
    logic          cpu_hold = 1'b0;
    logic          tb_fill = 1'b0;
    logic [AW-1:0] mem [0:511];

    int n_chk = 0, n_err = 0;
    int n_wr = 0, n_cs = 0, n_ten = 0, n_bad = 0;
    logic req_prev = 1'b0;
    logic [25:0] v;
    int t0, w0, c0, b0, bad;
    bit ok;
    string tag;

    always #4 clk = ~clk;

    dmac_chain_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
        .irq(irq), .busy(busy)
    );

    function automatic logic [15:0] pat(input int a);
        case (a)
            'h180: return 16'd3;
            'h181: return 16'h0020;
            'h182: return 16'h00A0;
            'h183: return 16'h0190;
            'h190: return 16'd0;
            'h191: return 16'h0060;
            'h192: return 16'h00E0;
            'h193: return 16'h01A0;
            'h1A0: return 16'd2;
            'h1A1: return 16'h0030;
            'h1A2: return 16'h00C0;
            'h1A3: return 16'd0;
            default: return (a >= 'h80) ? SENT : (16'h5A00 ^ 16'(a * 37));
        endcase
    endfunction

    always @(posedge clk) begin
        if (tb_fill) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
        end else if (!mem_cs_n) begin
            if (!mem_we_n) mem[mem_addr[8:0]] <= mem_wdata;
            if (!mem_rd_n) mem_rdata <= mem[mem_addr[8:0]];
        end
    end

    always @(posedge clk) bus_gnt <= rst_n && bus_req && !cpu_hold;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n) n_wr++;
            if (!mem_cs_n) n_cs++;
            if (bus_req && !req_prev) n_ten++;
            if (!mem_cs_n && !bus_gnt) n_bad++;
        end
        req_prev = bus_req;
    end

    task automatic check(input string rq, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic refill();
        @(negedge clk); tb_fill = 1'b1;
        @(negedge clk); tb_fill = 1'b0;
    endtask

    task automatic wait_irq(output bit got);
        got = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
        end
    endtask

    task automatic snap();
        t0 = n_ten; w0 = n_wr; c0 = n_cs; b0 = n_bad;
    endtask

    function automatic int copy_bad(input int s, input int d, input int n);
        int e = 0;
        for (int i = 0; i < n; i++) if (mem[d+i] !== pat(s+i)) e++;
        if (mem[d+n] !== SENT) e++;
        return e;
    endfunction

    task automatic clear_irq(input string rq);
        cfg_wr(SEL_CLR, '0);
        @(negedge clk);
        check(rq, int'(irq), 0, "irq after clear");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        refill();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8", int'(mem_cs_n), 1, "cs_n at reset");
        check("R8", int'(mem_rd_n), 1, "rd_n at reset");
        check("R8", int'(mem_we_n), 1, "we_n at reset");
        check("R8", int'(bus_req), 0, "bus_req at reset");
        check("R9", int'(irq), 0, "irq at reset");
        check("R2", int'(busy), 0, "busy at reset");

        // R6 default group length of 4
        refill(); snap();
        cfg_wr(SEL_SRC, 16'h0020); cfg_wr(SEL_DST, 16'h00A0); cfg_wr(SEL_CNT, 16'd8);
        cfg_wr(SEL_CTRL, 16'h0009);
        wait_irq(ok);
        check("R6", int'(ok), 1, "default group job done");
        check("R6", n_ten - t0, 2, "tenures with reset group length");
        check("R1", copy_bad('h20, 'hA0, 8), 0, "copy mismatches");
        clear_irq("R9");

        // vector table: policies and group lengths
        for (int k = 0; k < 7; k++) begin
            v = VEC[k];
            tag = (v[25:24] == 2'd0) ? "R5" : (v[25:24] == 2'd1) ? "R6" : "R7";
            refill(); snap();
            cfg_wr(SEL_SRC, 16'h0020); cfg_wr(SEL_DST, 16'h00A0);
            cfg_wr(SEL_CNT, 16'(v[15:8])); cfg_wr(SEL_GLEN, 16'(v[23:16]));
            cfg_wr(SEL_CTRL, 16'({v[25:24], 3'b001}));
            wait_irq(ok);
            check("R9", int'(ok), 1, "irq at end of job");
            check(tag, n_ten - t0, int'(v[7:0]), "tenure count");
            check("R1", copy_bad('h20, 'hA0, int'(v[15:8])), 0, "copy mismatches");
            check("R1", n_wr - w0, int'(v[15:8]), "write strobes");
            repeat (10) @(negedge clk);
            check("R9", int'(irq), 1, "irq held");
            clear_irq("R9");
        end

        // R3 paced single-policy job
        refill(); snap();
        cfg_wr(SEL_SRC, 16'h0040); cfg_wr(SEL_DST, 16'h0100); cfg_wr(SEL_CNT, 16'd4);
        cfg_wr(SEL_CTRL, 16'h0003);
        repeat (30) @(negedge clk);
        check("R3", n_wr - w0, 0, "writes while dreq low");
        check("R3", int'(busy), 1, "busy while waiting for dreq");
        dreq = 1'b1;
        wait_irq(ok);
        dreq = 1'b0;
        check("R3", int'(ok), 1, "paced job done");
        check("R3", copy_bad('h40, 'h100, 4), 0, "paced copy mismatches");
        check("R5", n_ten - t0, 4, "paced single tenures");
        clear_irq("R9");

        // R10 zero-length standalone job
        refill(); snap();
        cfg_wr(SEL_CNT, 16'd0);
        cfg_wr(SEL_CTRL, 16'h0001);
        repeat (3) @(negedge clk);
        check("R10", int'(irq), 1, "irq after zero count");
        check("R10", n_cs - c0, 0, "bus strobes for zero count");
        check("R10", n_ten - t0, 0, "tenures for zero count");
        clear_irq("R9");

        // R4 descriptor list with an empty middle entry, whole-job policy
        refill(); snap();
        cfg_wr(SEL_DESC, 16'h0180);
        cfg_wr(SEL_CTRL, 16'h0015);
        wait_irq(ok);
        check("R4", int'(ok), 1, "list done");
        check("R4", copy_bad('h20, 'hA0, 3), 0, "first descriptor copy");
        check("R4", copy_bad('h30, 'hC0, 2), 0, "third descriptor copy");
        check("R10", int'(mem['hE0]), int'(SENT), "empty descriptor target untouched");
        check("R4", n_wr - w0, 5, "list writes");
        check("R4", n_cs - c0, 22, "list strobes");
        check("R7", n_ten - t0, 1, "list tenures");
        clear_irq("R9");

        // R11 start during a job is ignored; R8 no strobes without grant
        refill(); snap();
        cpu_hold = 1'b1;
        cfg_wr(SEL_SRC, 16'h0020); cfg_wr(SEL_DST, 16'h00A0); cfg_wr(SEL_CNT, 16'd6);
        cfg_wr(SEL_CTRL, 16'h0011);
        repeat (10) @(negedge clk);
        check("R8", n_cs - c0, 0, "strobes while grant withheld");
        check("R8", int'(bus_req), 1, "request while waiting");
        cfg_wr(SEL_SRC, 16'h0040); cfg_wr(SEL_CNT, 16'd2);
        cfg_wr(SEL_CTRL, 16'h0001);
        cpu_hold = 1'b0;
        wait_irq(ok);
        check("R11", int'(ok), 1, "first job done");
        check("R11", copy_bad('h20, 'hA0, 6), 0, "original job copy");
        check("R11", n_ten - t0, 1, "original policy kept");
        repeat (20) @(negedge clk);
        check("R11", int'(busy), 0, "no second job");
        check("R8", n_bad - b0, 0, "strobes without grant");
        clear_irq("R9");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule